// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block watches a small group of external interrupt pins and turns their activity into interrupt requests for a processor. Each pin has a two-bit sense setting that picks one of four behaviours. In level mode a pin requests for as long as it is held low. In the three edge modes (any change, falling, rising) the controller compares successive clocked samples and records a hit in a sticky pending flag. Every pin first passes through a two-flop synchroniser clocked by the system clock. It then goes through one more sample register, so that the current and the previous sample can be compared.

Software reaches three byte-wide registers through a simple write strobe and a combinational read port. The sense register is at address 0x6A. A per-pin mask register is at 0x3D. The pending flag register is at 0x3C, and writing a 1 to one of its bits clears that flag. The request vector shows each pin whose request is pending and unmasked. A single interrupt line, qualified by a global enable input, presents the lowest-numbered requesting pin as a vector index. An acknowledge input clears the flag of the pin that is being presented.

Top module: `eint_ctrl`

## Requirements
- R1: After reset the sense, mask and flag registers all read 0x00, which puts every pin in level mode. A byte written to address 0x6A reads back unchanged from 0x6A. Mask bits occupy positions 3:0 of address 0x3D and flag bits occupy positions 3:0 of address 0x3C.
- R2: Pin i is controlled by sense bits [2i+1:2i]. Pin 0 uses bits 1:0 and pin 3 uses bits 7:6.
- R3: Sense code 2'b00 (level) asserts the pin's request while its synchronised sample is low. The request appears two clock edges after the pin goes low and drops two edges after the pin goes high. Level mode never sets the flag.
- R4: Sense code 2'b01 sets the pin's flag on any change between two consecutive samples.
- R5: Sense code 2'b10 sets the pin's flag on a high-to-low change between two consecutive samples.
- R6: Sense code 2'b11 sets the pin's flag on a low-to-high change between two consecutive samples.
- R7: An edge event sets the flag even while the pin's mask bit is 0, and the flag stays set until it is cleared. Request bit i equals the pin's pending state ANDed with mask bit i.
- R8: The interrupt line is high only when the global enable is 1 and at least one request bit is set.
- R9: When several requests are set, the interrupt index is the lowest-numbered requesting pin.
- R10: An acknowledge while the interrupt line is high clears the flag of the indexed pin at the next edge. Writing a 1 to a bit of the flag register also clears that flag.
- R11: Rewriting a pin's sense bits while its mask bit is 1 can raise a request at once. One case is a pin held low being switched into level mode. If the mask bit is cleared first, no request appears.
- R12: In an edge mode, a pin pulse that lasts one full clock period sets the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | 4 | Asynchronous external interrupt pins |
| gie | input | 1 | Global interrupt enable |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data (combinational) |
| irq_ack | input | 1 | Acknowledge of the presented interrupt |
| req_vec | output | 4 | Per-pin pending and unmasked requests |
| irq | output | 1 | Prioritised interrupt request |
| irq_idx | output | 2 | Index of the presented pin |

## Verification
The bench puts all four sense codes through both transition directions on one pin. It then loads a different mode into each pin at once, which exposes a swapped or misaligned sense field as flags on the wrong pins. It checks level-mode latency edge by edge: an extra or missing synchroniser stage moves the request by one cycle. It also sends a pulse exactly one clock long, which a design sampling too slowly would miss. Further cases cover the priority walk under acknowledge, write-one-to-clear, and the gating by global enable and mask. The last case is the spurious request seen when a pin held low is switched into level mode unmasked, against the silent result when the mask is cleared first. A design that latched level requests, or that gated flag setting by the mask, fails these checks.

// File: rtl/eint_pkg.sv
package eint_pkg;

    typedef enum logic [1:0] {
        SENSE_LOW  = 2'b00,
        SENSE_ANY  = 2'b01,
        SENSE_FALL = 2'b10,
        SENSE_RISE = 2'b11
    } sense_e;

    typedef struct packed {
        logic now;
        logic prev;
    } sample_t;

    function automatic logic edge_hit(sense_e mode, sample_t s);
        case (mode)
            SENSE_ANY:  return s.now ^ s.prev;
            SENSE_FALL: return s.prev & ~s.now;
            SENSE_RISE: return ~s.prev & s.now;
            default:    return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/eint_chan.sv
module eint_chan
    import eint_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   pin_in,
    input  sense_e mode,
    input  logic   clr,
    output logic   flag_o,
    output logic   level_o
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   flag_q;
    sample_t                smp;
    logic                   hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '1;
            prev_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], pin_in};
            prev_q <= sync_q[SYNC_STAGES-1];
        end
    end

    always_comb begin
        smp.now  = sync_q[SYNC_STAGES-1];
        smp.prev = prev_q;
        hit      = edge_hit(mode, smp);
    end

    always_ff @(posedge clk) begin
        if (rst)      flag_q <= 1'b0;
        else if (hit) flag_q <= 1'b1;
        else if (clr) flag_q <= 1'b0;
    end

    assign flag_o  = flag_q;
    assign level_o = (mode == SENSE_LOW) && !smp.now;

    p_level_noflag_r3: assert property (@(posedge clk) disable iff (rst)
        (mode == SENSE_LOW && !flag_q) |=> !flag_q);

    p_flag_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !clr) |=> flag_q);

    p_flag_clear_r10: assert property (@(posedge clk) disable iff (rst)
        (clr && !hit) |=> !flag_q);

endmodule

// File: rtl/eint_regs.sv
module eint_regs #(
    parameter int          NPINS      = 4,
    parameter int          AW         = 8,
    parameter int          DW         = 8,
    parameter logic [7:0]  SENSE_ADDR = 8'h6A,
    parameter logic [7:0]  MASK_ADDR  = 8'h3D,
    parameter logic [7:0]  FLAG_ADDR  = 8'h3C,
    localparam int         SW         = 2 * NPINS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_we,
    input  logic [AW-1:0]    bus_addr,
    input  logic [DW-1:0]    bus_wdata,
    input  logic [NPINS-1:0] flags,
    output logic [SW-1:0]    sense_q,
    output logic [NPINS-1:0] mask_q,
    output logic [NPINS-1:0] w1c,
    output logic [DW-1:0]    bus_rdata
);

    logic hit_sense, hit_mask, hit_flag;

    assign hit_sense = bus_addr == AW'(SENSE_ADDR);
    assign hit_mask  = bus_addr == AW'(MASK_ADDR);
    assign hit_flag  = bus_addr == AW'(FLAG_ADDR);

    always_ff @(posedge clk) begin
        if (rst) begin
            sense_q <= '0;
            mask_q  <= '0;
        end else if (bus_we) begin
            if (hit_sense) sense_q <= bus_wdata[SW-1:0];
            if (hit_mask)  mask_q  <= bus_wdata[NPINS-1:0];
        end
    end

    assign w1c = (bus_we && hit_flag) ? bus_wdata[NPINS-1:0] : '0;

    always_comb begin
        bus_rdata = '0;
        if (hit_sense)     bus_rdata = DW'(sense_q);
        else if (hit_mask) bus_rdata = DW'(mask_q);
        else if (hit_flag) bus_rdata = DW'(flags);
    end

    p_sense_wr_r1: assert property (@(posedge clk) disable iff (rst)
        (bus_we && hit_sense) |=> (sense_q == $past(bus_wdata[SW-1:0])));

endmodule

// File: rtl/eint_prio.sv
module eint_prio #(
    parameter int NPINS = 4,
    localparam int IDXW = $clog2(NPINS)
) (
    input  logic [NPINS-1:0] req,
    input  logic             gie,
    output logic             irq,
    output logic [IDXW-1:0]  idx
);

    always_comb begin
        idx = '0;
        for (int i = NPINS - 1; i >= 0; i--) begin
            if (req[i]) idx = IDXW'(i);
        end
        irq = gie && (req != '0);
    end

endmodule

// File: rtl/eint_ctrl.sv
module eint_ctrl
    import eint_pkg::*;
#(
    parameter int NPINS       = 4,
    parameter int AW          = 8,
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2,
    localparam int IDXW       = $clog2(NPINS),
    localparam int SW         = 2 * NPINS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NPINS-1:0] pin_in,
    input  logic             gie,
    input  logic             bus_we,
    input  logic [AW-1:0]    bus_addr,
    input  logic [DW-1:0]    bus_wdata,
    output logic [DW-1:0]    bus_rdata,
    input  logic             irq_ack,
    output logic [NPINS-1:0] req_vec,
    output logic             irq,
    output logic [IDXW-1:0]  irq_idx
);

    logic [SW-1:0]    sense_q;
    logic [NPINS-1:0] mask_q;
    logic [NPINS-1:0] w1c;
    logic [NPINS-1:0] flags;
    logic [NPINS-1:0] level;
    logic [NPINS-1:0] pend;
    logic [NPINS-1:0] below;

    eint_regs #(.NPINS(NPINS), .AW(AW), .DW(DW)) u_regs (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .flags(flags), .sense_q(sense_q),
        .mask_q(mask_q), .w1c(w1c), .bus_rdata(bus_rdata)
    );

    for (genvar i = 0; i < NPINS; i++) begin : g_chan
        sense_e mode;
        logic   clr;
        assign mode = sense_e'(sense_q[2*i +: 2]);
        assign clr  = w1c[i] || (irq_ack && irq && irq_idx == IDXW'(i));
        assign pend[i] = (mode == SENSE_LOW) ? level[i] : flags[i];

        eint_chan #(.SYNC_STAGES(SYNC_STAGES)) u_chan (
            .clk(clk), .rst(rst), .pin_in(pin_in[i]), .mode(mode),
            .clr(clr), .flag_o(flags[i]), .level_o(level[i])
        );
    end

    assign req_vec = pend & mask_q;

    eint_prio #(.NPINS(NPINS)) u_prio (
        .req(req_vec), .gie(gie), .irq(irq), .idx(irq_idx)
    );

    assign below = (NPINS'(1) << irq_idx) - NPINS'(1);

    p_irq_gated_r8: assert property (@(posedge clk) disable iff (rst)
        irq |-> (gie && req_vec != '0));

    p_idx_lowest_r9: assert property (@(posedge clk) disable iff (rst)
        irq |-> (req_vec[irq_idx] && (req_vec & below) == '0));

endmodule

// File: tb/tb_eint_ctrl.sv
module tb_eint_ctrl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] pin_in = 4'hF;
    logic       gie = 1'b0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       irq_ack = 1'b0;
    logic [3:0] req_vec;
    logic       irq;
    logic [1:0] irq_idx;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    localparam logic [7:0] A_SENSE = 8'h6A;
    localparam logic [7:0] A_MASK  = 8'h3D;
    localparam logic [7:0] A_FLAG  = 8'h3C;

    // {mode[1:0], start level, end level, expected flag}
    localparam logic [4:0] VEC [8] = '{
        5'b00_10_0, 5'b00_01_0,
        5'b01_10_1, 5'b01_01_1,
        5'b10_10_1, 5'b10_01_0,
        5'b11_10_0, 5'b11_01_1
    };

    eint_ctrl dut (
        .clk(clk), .rst(rst), .pin_in(pin_in), .gie(gie), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_ack(irq_ack), .req_vec(req_vec), .irq(irq), .irq_idx(irq_idx)
    );

    always #5 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
        #1;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    initial begin
        #500000;
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual 0x0 expected 0x1");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;

        // R1 reset state
        rd(A_SENSE, v); chk("R1 sense reset", 32'(v), 32'h00);
        rd(A_MASK, v);  chk("R1 mask reset", 32'(v), 32'h00);
        rd(A_FLAG, v);  chk("R1 flag reset", 32'(v), 32'h00);
        chk("R1 req reset", 32'(req_vec), 32'h0);
        chk("R8 irq reset", 32'(irq), 32'h0);

        // R4 R5 R6 R3: mode table on pin 0
        foreach (VEC[k]) begin
            wr(A_SENSE, {6'b0, VEC[k][4:3]});
            @(negedge clk); pin_in[0] = VEC[k][2];
            wait_cyc(4);
            wr(A_FLAG, 8'h0F);
            @(negedge clk); pin_in[0] = VEC[k][1];
            wait_cyc(4);
            rd(A_FLAG, v);
            chk($sformatf("R4/R5/R6 table entry %0d", k), 32'(v[0]), 32'(VEC[k][0]));
        end
        @(negedge clk); pin_in = 4'hF;
        wait_cyc(4);

        // R2 field mapping: pin3 rise, pin2 fall, pin1 toggle, pin0 level
        wr(A_SENSE, 8'hE4);
        rd(A_SENSE, v); chk("R1 sense readback", 32'(v), 32'hE4);
        wr(A_FLAG, 8'h0F);
        @(negedge clk); pin_in = 4'h0;
        wait_cyc(4);
        rd(A_FLAG, v); chk("R2 flags after fall", 32'(v), 32'h06);
        @(negedge clk); pin_in = 4'hF;
        wait_cyc(4);
        rd(A_FLAG, v); chk("R2 flags after rise", 32'(v), 32'h0E);

        // R7 masked flags hold, mask gates requests
        chk("R7 masked req", 32'(req_vec), 32'h0);
        wr(A_MASK, 8'h0F);
        rd(A_MASK, v); chk("R1 mask readback", 32'(v), 32'h0F);
        chk("R7 unmasked req", 32'(req_vec), 32'hE);
        chk("R8 irq without gie", 32'(irq), 32'h0);
        @(negedge clk); gie = 1'b1; #1;
        chk("R8 irq with gie", 32'(irq), 32'h1);
        chk("R9 lowest index", 32'(irq_idx), 32'h1);

        // R10 acknowledge walk and write-one-to-clear
        @(negedge clk); irq_ack = 1'b1;
        @(negedge clk); irq_ack = 1'b0; #1;
        chk("R10 ack clears pin1", 32'(req_vec), 32'hC);
        chk("R9 next index", 32'(irq_idx), 32'h2);
        @(negedge clk); irq_ack = 1'b1;
        @(negedge clk); irq_ack = 1'b0; #1;
        chk("R10 ack clears pin2", 32'(irq_idx), 32'h3);
        wr(A_FLAG, 8'h08);
        chk("R10 w1c clears pin3", 32'(req_vec), 32'h0);
        chk("R10 irq drops", 32'(irq), 32'h0);

        // R3 level latency
        @(negedge clk); pin_in[0] = 1'b0;
        @(posedge clk); #1;
        chk("R3 level after one edge", 32'(req_vec[0]), 32'h0);
        @(posedge clk); #1;
        chk("R3 level after two edges", 32'(req_vec[0]), 32'h1);
        chk("R9 level index", 32'(irq_idx), 32'h0);
        rd(A_FLAG, v); chk("R3 level sets no flag", 32'(v[0]), 32'h0);
        @(negedge clk); pin_in[0] = 1'b1;
        wait_cyc(3);
        chk("R3 level released", 32'(req_vec), 32'h0);

        // R12 one-clock pulse, falling mode, masked
        wr(A_MASK, 8'h00);
        wr(A_SENSE, 8'hE6);
        wr(A_FLAG, 8'h0F);
        @(negedge clk); pin_in[0] = 1'b0;
        @(negedge clk); pin_in[0] = 1'b1;
        wait_cyc(4);
        rd(A_FLAG, v); chk("R12 short pulse caught", 32'(v[0]), 32'h1);

        // R11 spurious request on mode rewrite
        wr(A_SENSE, 8'hE7);
        wr(A_FLAG, 8'h0F);
        wr(A_MASK, 8'h01);
        @(negedge clk); pin_in[0] = 1'b0;
        wait_cyc(4);
        chk("R11 rising mode quiet", 32'(req_vec), 32'h0);
        wr(A_SENSE, 8'hE4);
        chk("R11 spurious unmasked", 32'(req_vec[0]), 32'h1);
        wr(A_SENSE, 8'hE7);
        wr(A_MASK, 8'h00);
        wr(A_SENSE, 8'hE4);
        chk("R11 masked rewrite req", 32'(req_vec), 32'h0);
        chk("R11 masked rewrite irq", 32'(irq), 32'h0);
        wr(A_SENSE, 8'hE7);
        wr(A_MASK, 8'h01);
        chk("R11 no request after unmask", 32'(req_vec), 32'h0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule